// File: doc/BRIEF.md
# Paged Memory Window Mapper

This block sits between a processor with a 16-bit address bus and two memories: a 256 KB ROM and a 128 KB RAM, both arranged as 16 KB pages. It splits the processor's 64 KB space into four 16 KB windows.

- The lowest window always shows ROM page 0.
- The highest window always shows RAM page 0.
- Each of the two middle windows is steered by its own I/O-port register. One bit of that register chooses the device, and the low bits choose the page.

For every memory request the block produces the physical address and one active-low select for each memory.

The block also has an absolute mode for linear data moves across both memories. An I/O write to a dedicated port loads a high address byte and arms the mode. The next memory transaction is the opcode fetch of the move instruction, and it is still mapped through the windows. The transaction after that uses the 24-bit value {high byte, CPU address} as a linear address. In that linear space ROM occupies 0x00000 to 0x0BFFF and RAM occupies 0x0C000 to 0x2BFFF. After that single data transaction the mode disarms itself.

Top module: `bank_mapper`

## Requirements
- R1: After reset both switchable window registers hold ROM page 0 and absolute mode is idle, so a request in 0x4000-0xBFFF selects ROM at physical offset addr[13:0].
- R2: A request to CPU addresses 0x0000-0x3FFF selects ROM with physical address addr[13:0] (page 0).
- R3: A request to CPU addresses 0xC000-0xFFFF selects RAM with physical address addr[13:0] (page 0).
- R4: An I/O write to port 5 loads the register for window 0x4000-0x7FFF, and a write to port 6 loads the register for window 0x8000-0xBFFF. In either register, bit 6 = 1 selects RAM and bit 6 = 0 selects ROM.
- R5: A window mapped to ROM drives physical {reg[3:0], addr[13:0]}. A window mapped to RAM drives {1'b0, reg[2:0], addr[13:0]}. Register bits 7, 5 and 4 have no effect, and neither does bit 3 when RAM is chosen.
- R6: Chip selects are active low. Both are high when no memory request is present, never both low, and exactly one is low on any banked request.
- R7: An I/O write to port 7 loads the high address byte and arms absolute mode. The next memory request is mapped through the windows, and the one after it is decoded as absolute.
- R8: For absolute address A = {high byte, addr}, the decode is as follows. If A < 0x0C000, ROM is selected with physical address A. If 0x0C000 <= A < 0x2C000, RAM is selected with physical address A - 0x0C000. Otherwise neither select is low and the physical address is 0.
- R9: Absolute mode disarms after its one data transaction, and the following request is mapped through the windows again.
- R10: I/O writes to any port other than 5, 6 and 7 change no mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor address bus |
| mem_req | input | 1 | One-cycle strobe marking a memory transaction |
| io_wr | input | 1 | One-cycle strobe marking an I/O write |
| io_port | input | 8 | I/O port number of the write |
| io_data | input | 8 | I/O write data |
| phys_addr | output | 18 | Physical memory address |
| rom_cs_n | output | 1 | ROM select, active low |
| ram_cs_n | output | 1 | RAM select, active low |

## Verification
The observable state consists of the two window registers and the absolute-mode stage.

- A corrupted window register shows up on the next request into that window, as a wrong page field or as the wrong select going low.
- A stage that is off by one transaction shows up on the first or second request after the arming write. The opcode fetch would then be decoded linearly, or the data access would be decoded through the windows.
- A stage that never disarms corrupts every request that follows.

The bench keeps its own model of these registers and compares every request, so any such fault is reported on the first transaction that reaches the faulty state.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;
    typedef enum logic [1:0] {
        ABS_IDLE  = 2'd0,
        ABS_ARMED = 2'd1,
        ABS_APPLY = 2'd2
    } abs_stage_e;

    typedef struct packed {
        logic [7:0] win_a;
        logic [7:0] win_b;
        logic [7:0] abs_hi;
        abs_stage_e stage;
    } map_state_t;
endpackage

// File: rtl/mapper_regs.sv
module mapper_regs
    import bank_mapper_pkg::*;
#(
    parameter int WIN_A_PORT = 5,
    parameter int WIN_B_PORT = 6,
    parameter int ABS_PORT   = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       io_wr,
    input  logic [7:0] io_port,
    input  logic [7:0] io_data,
    input  logic       mem_req,
    output map_state_t st_q
);
    localparam int NWIN = 2;
    localparam logic [7:0] WIN_PORTS [NWIN] = '{8'(WIN_A_PORT), 8'(WIN_B_PORT)};

    logic [NWIN-1:0] win_we;
    map_state_t      st_d;

    for (genvar w = 0; w < NWIN; w++) begin : g_we
        assign win_we[w] = io_wr && (io_port == WIN_PORTS[w]);
    end

    always_comb begin
        st_d = st_q;
        if (mem_req) begin
            case (st_q.stage)
                ABS_ARMED: st_d.stage = ABS_APPLY;
                ABS_APPLY: st_d.stage = ABS_IDLE;
                default:   st_d.stage = ABS_IDLE;
            endcase
        end
        if (win_we[0]) st_d.win_a = io_data;
        if (win_we[1]) st_d.win_b = io_data;
        if (io_wr && io_port == 8'(ABS_PORT)) begin
            st_d.abs_hi = io_data;
            st_d.stage  = ABS_ARMED;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{win_a: 8'h00, win_b: 8'h00, abs_hi: 8'h00, stage: ABS_IDLE};
        end else begin
            st_q <= st_d;
        end
    end

    // R7: an arming write leaves the stage armed
    a_r7_arm: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr && io_port == 8'(ABS_PORT)) |=> (st_q.stage == ABS_ARMED));

    // R9: the applied stage lasts for one transaction only
    a_r9_disarm: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stage == ABS_APPLY && mem_req && !io_wr) |=> (st_q.stage == ABS_IDLE));

    // R10: window registers change only on their own ports
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(win_we[0] || win_we[1]) |=> ($stable(st_q.win_a) && $stable(st_q.win_b)));
endmodule

// File: rtl/mapper_decode.sv
module mapper_decode
    import bank_mapper_pkg::*;
#(
    parameter int OFS_W     = 14,
    parameter int ROM_PG_W  = 4,
    parameter int RAM_PG_W  = 3,
    parameter int DEV_BIT   = 6,
    parameter int ABS_ROM_P = 3,
    parameter int PHYS_W    = OFS_W + ROM_PG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              mem_req,
    input  map_state_t        st_q,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              rom_cs_n,
    output logic              ram_cs_n
);
    localparam int          ABS_W    = 24;
    localparam logic [23:0] RAM_BASE = 24'(ABS_ROM_P) << OFS_W;
    localparam logic [23:0] RAM_END  = RAM_BASE + (24'(1 << RAM_PG_W) << OFS_W);

    logic [ABS_W-1:0]  abs_a;
    logic [ABS_W-1:0]  abs_ram;
    logic [7:0]        win_reg;
    logic [OFS_W-1:0]  ofs;
    logic              sel_rom;
    logic              sel_ram;
    logic              unused_bits;

    assign ofs         = cpu_addr[OFS_W-1:0];
    assign abs_a       = {st_q.abs_hi, cpu_addr};
    assign abs_ram     = abs_a - RAM_BASE;
    assign unused_bits = ^{st_q.win_a, st_q.win_b, clk, rst_n};

    always_comb begin
        sel_rom   = 1'b0;
        sel_ram   = 1'b0;
        phys_addr = '0;
        win_reg   = (cpu_addr[15:14] == 2'd1) ? st_q.win_a : st_q.win_b;
        if (st_q.stage == ABS_APPLY) begin
            if (abs_a < RAM_BASE) begin
                sel_rom   = 1'b1;
                phys_addr = abs_a[PHYS_W-1:0];
            end else if (abs_a < RAM_END) begin
                sel_ram   = 1'b1;
                phys_addr = abs_ram[PHYS_W-1:0];
            end
        end else begin
            case (cpu_addr[15:14])
                2'd0: begin
                    sel_rom   = 1'b1;
                    phys_addr = PHYS_W'(ofs);
                end
                2'd3: begin
                    sel_ram   = 1'b1;
                    phys_addr = PHYS_W'(ofs);
                end
                default: begin
                    if (win_reg[DEV_BIT]) begin
                        sel_ram   = 1'b1;
                        phys_addr = PHYS_W'({win_reg[RAM_PG_W-1:0], ofs});
                    end else begin
                        sel_rom   = 1'b1;
                        phys_addr = PHYS_W'({win_reg[ROM_PG_W-1:0], ofs});
                    end
                end
            endcase
        end
    end

    assign rom_cs_n = !(mem_req && sel_rom);
    assign ram_cs_n = !(mem_req && sel_ram);

    // R6: never both memories at once
    a_r6_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!rom_cs_n, !ram_cs_n}));

    // R6: no select without a request
    a_r6_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> (rom_cs_n && ram_cs_n));
endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
#(
    parameter int OFS_W      = 14,
    parameter int ROM_PAGES  = 16,
    parameter int RAM_PAGES  = 8,
    parameter int WIN_A_PORT = 5,
    parameter int WIN_B_PORT = 6,
    parameter int ABS_PORT   = 7,
    parameter int DEV_BIT    = 6,
    parameter int ABS_ROM_P  = 3,
    parameter int PHYS_W     = OFS_W + $clog2(ROM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       cpu_addr,
    input  logic              mem_req,
    input  logic              io_wr,
    input  logic [7:0]        io_port,
    input  logic [7:0]        io_data,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              rom_cs_n,
    output logic              ram_cs_n
);
    localparam int ROM_PG_W = $clog2(ROM_PAGES);
    localparam int RAM_PG_W = $clog2(RAM_PAGES);

    map_state_t st_q;

    mapper_regs #(
        .WIN_A_PORT(WIN_A_PORT),
        .WIN_B_PORT(WIN_B_PORT),
        .ABS_PORT  (ABS_PORT)
    ) regs_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .io_wr  (io_wr),
        .io_port(io_port),
        .io_data(io_data),
        .mem_req(mem_req),
        .st_q   (st_q)
    );

    mapper_decode #(
        .OFS_W    (OFS_W),
        .ROM_PG_W (ROM_PG_W),
        .RAM_PG_W (RAM_PG_W),
        .DEV_BIT  (DEV_BIT),
        .ABS_ROM_P(ABS_ROM_P),
        .PHYS_W   (PHYS_W)
    ) dec_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .cpu_addr (cpu_addr),
        .mem_req  (mem_req),
        .st_q     (st_q),
        .phys_addr(phys_addr),
        .rom_cs_n (rom_cs_n),
        .ram_cs_n (ram_cs_n)
    );

    // R3: top window is RAM page 0 whenever absolute decode is not applied
    a_r3_top_ram: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && st_q.stage != ABS_APPLY && cpu_addr[15:14] == 2'd3)
        |-> (!ram_cs_n && phys_addr == PHYS_W'(cpu_addr[OFS_W-1:0])));

    // R2: bottom window is ROM page 0 whenever absolute decode is not applied
    a_r2_bot_rom: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && st_q.stage != ABS_APPLY && cpu_addr[15:14] == 2'd0)
        |-> (!rom_cs_n && phys_addr == PHYS_W'(cpu_addr[OFS_W-1:0])));
endmodule

// File: tb/bank_mapper_tb.sv
module bank_mapper_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        mem_req = 1'b0;
    logic        io_wr = 1'b0;
    logic [7:0]  io_port = '0;
    logic [7:0]  io_data = '0;
    logic [17:0] phys_addr;
    logic        rom_cs_n;
    logic        ram_cs_n;

    int n_chk = 0;
    int n_fail = 0;

    logic [7:0] m_wa = 8'h00;
    logic [7:0] m_wb = 8'h00;
    logic [7:0] m_hi = 8'h00;
    int         m_stg = 0;

    always #(CLK_P/2) clk = ~clk;

    bank_mapper dut_i (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .mem_req(mem_req),
        .io_wr(io_wr), .io_port(io_port), .io_data(io_data),
        .phys_addr(phys_addr), .rom_cs_n(rom_cs_n), .ram_cs_n(ram_cs_n)
    );

    function automatic logic [19:0] expect_map(input logic [15:0] a);
        logic [23:0] abs_v;
        logic [7:0]  r;
        if (m_stg == 2) begin
            abs_v = {m_hi, a};
            if (abs_v < 24'h00C000) return {2'b01, abs_v[17:0]};
            if (abs_v < 24'h02C000) return {2'b10, 18'(abs_v - 24'h00C000)};
            return {2'b11, 18'h0};
        end
        if (a[15:14] == 2'd0) return {2'b01, 4'h0, a[13:0]};
        if (a[15:14] == 2'd3) return {2'b10, 4'h0, a[13:0]};
        r = (a[15:14] == 2'd1) ? m_wa : m_wb;
        if (r[6]) return {2'b10, 1'b0, r[2:0], a[13:0]};
        return {2'b01, r[3:0], a[13:0]};
    endfunction

    task automatic check(input string req, input logic [19:0] got, input logic [19:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got cs_n=%b phys=%h expected cs_n=%b phys=%h",
                     req, got[19:18], got[17:0], exp[19:18], exp[17:0]);
        end
    endtask

    task automatic do_io(input logic [7:0] p, input logic [7:0] d);
        @(negedge clk);
        io_wr = 1'b1; io_port = p; io_data = d;
        @(posedge clk);
        #1 io_wr = 1'b0;
        if (p == 8'd5) m_wa = d;
        else if (p == 8'd6) m_wb = d;
        else if (p == 8'd7) begin m_hi = d; m_stg = 1; end
    endtask

    task automatic do_mem(input logic [15:0] a, input string req_override);
        string req;
        @(negedge clk);
        cpu_addr = a; mem_req = 1'b1;
        #1;
        if (req_override != "") req = req_override;
        else if (m_stg == 2) req = "R8";
        else if (a[15:14] == 2'd0) req = "R2";
        else if (a[15:14] == 2'd3) req = "R3";
        else req = "R5";
        check(req, {rom_cs_n, ram_cs_n, phys_addr}, expect_map(a));
        @(posedge clk);
        if (m_stg == 1) m_stg = 2; else if (m_stg == 2) m_stg = 0;
        #1 mem_req = 1'b0;
        #1 check("R6", {rom_cs_n, ram_cs_n, 18'h0}, {2'b11, 18'h0});
    endtask

    task automatic run_all();
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1: reset state of both windows
        do_mem(16'h4000, "R1");
        do_mem(16'h8123, "R1");
        do_mem(16'h3FFF, "R2");
        do_mem(16'hC000, "R3");
        do_mem(16'hFFFF, "R3");
        // R4/R5: RAM page 7 with bit 3 set (ignored), ROM page 15, ignored upper bits
        do_io(8'd5, 8'h4F);
        do_mem(16'h4001, "R4");
        do_io(8'd6, 8'h0F);
        do_mem(16'hBFFF, "R4");
        do_io(8'd6, 8'hB5);
        do_mem(16'h8000, "R5");
        // R10: foreign port write leaves windows alone
        do_io(8'd3, 8'hFF);
        do_mem(16'h4000, "R10");
        do_mem(16'h8000, "R10");
        // R7/R8/R9: fetch stays banked, data is linear, then back to banked
        do_io(8'd7, 8'h01);
        do_mem(16'h4000, "R7");
        do_mem(16'h2345, "R8");
        do_mem(16'h2345, "R9");
        // R8 boundaries
        do_io(8'd7, 8'h00); do_mem(16'h0000, "R7"); do_mem(16'hBFFF, "R8");
        do_io(8'd7, 8'h00); do_mem(16'h0000, "R7"); do_mem(16'hC000, "R8");
        do_io(8'd7, 8'h02); do_mem(16'h0000, "R7"); do_mem(16'hBFFF, "R8");
        do_io(8'd7, 8'h02); do_mem(16'h0000, "R7"); do_mem(16'hC000, "R8");
        do_mem(16'hC000, "R9");
        // random mix
        for (int i = 0; i < 400; i++) begin
            int kind;
            kind = int'($urandom_range(0, 9));
            if (kind < 2) do_io(8'(5 + $urandom_range(0, 1)), 8'($urandom));
            else if (kind == 2) do_io(8'd7, 8'($urandom_range(0, 3)));
            else if (kind == 3) do_io(8'($urandom_range(8, 255)), 8'($urandom));
            else do_mem(16'($urandom), "");
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                #(CLK_P * 150000);
                n_chk++; n_fail++;
                $display("FAIL watchdog: run did not finish");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule